// File: doc/BRIEF.md
# Single-Clock Queue with Occupancy and Error Flags

This block is a first-in first-out buffer that runs on one clock. It holds eight entries of eight bits by default. Storage is a ring of registers, addressed by a write pointer and a read pointer that each wrap from the last slot back to slot 0. A producer places a word with `push`. A consumer takes the oldest word with `pop`, and the word appears on `pop_data` after the clock edge that samples the request.

An occupancy state machine tracks the fill level and drives the flags. It has three states: `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_FULL`. It has four named transitions:

- `OCC_EMPTY` goes to `OCC_PARTIAL` when the first word is accepted (first fill).
- `OCC_PARTIAL` goes to `OCC_FULL` when the last free slot is taken (top-off).
- `OCC_FULL` goes to `OCC_PARTIAL` when a word is taken (free one).
- `OCC_PARTIAL` goes to `OCC_EMPTY` when the last word leaves (last drain).

A 4-bit count of 0 to 8 entries sits next to the state machine and drives the low-level flag. An illegal request is refused and leaves the contents untouched. The refusal is reported for one cycle on `err_over` (a push while full) or `err_under` (a pop while empty).

Top module: `sync_fifo_flags`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to empty. After that edge: `is_empty`=1, `is_full`=0, `err_over`=0, `err_under`=0, `low_level`=1 and `pop_data`=0.
- R2: Accepted words leave in the order they arrived. `pop_data` takes the next word on the rising edge that samples an accepted `pop`, and holds that value until the next accepted `pop`.
- R3: `err_over` is high for exactly the one cycle after an edge that sampled `push` while `is_full` was high. At all other times it is low.
- R4: A push while full is discarded. The stored words and their order are unchanged.
- R5: `err_under` is high for exactly the one cycle after an edge that sampled `pop` while `is_empty` was high. At all other times it is low.
- R6: A pop while empty leaves `pop_data` unchanged and does not move the read position. The next word pushed is the next word popped.
- R7: `is_empty` is high exactly when zero words are stored.
- R8: `is_full` is high exactly when DEPTH (8) words are stored.
- R9: `low_level` is high exactly when the stored count is strictly less than THRESH (default 4, legal range 1 to DEPTH).
- R10: A push and a pop in the same cycle, while the buffer is neither empty nor full, are both accepted. The count stays the same.
- R11: The pointers wrap around. Order and data are preserved across any number of passes around the ring.
- R12: When `push` and `pop` arrive together while full, the pop is accepted and the push is refused with `err_over`. When they arrive together while empty, the push is accepted and the pop is refused with `err_under`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| push_data | input | WIDTH (8) | Word to store |
| pop | input | 1 | Read request |
| pop_data | output | WIDTH (8) | Last word taken, registered |
| is_empty | output | 1 | No words stored |
| is_full | output | 1 | All slots occupied |
| err_over | output | 1 | One-cycle pulse: push refused because full |
| err_under | output | 1 | One-cycle pulse: pop refused because empty |
| low_level | output | 1 | Stored count below THRESH |

## Verification
A wrong state or count shows at the ports within one cycle. It appears on `is_empty`, `is_full` or `low_level` on the edge after the bad update, because all three come straight from registered state. A pointer that slips shows later, on `pop_data`: only when the affected slot is popped does the wrong word, or a repeated word, come out. For that reason the bench drains every fill to the end and checks each word. It also runs the ring through several wraps, so that a pointer fault cannot stay hidden in slots that are never read back.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

endpackage

// File: rtl/fifo_ptr.sv
// Ring pointer: steps by one on adv, wraps from DEPTH-1 to 0.
module fifo_ptr #(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/fifo_store.sv
// Register ring with a registered read port.
module fifo_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_word,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == PTR_W'(i))) begin
                slot[i] <= wr_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
        end else if (rd_en) begin
            rd_word <= slot[rd_addr];
        end
    end
endmodule

// File: rtl/fifo_ctrl.sv
// Occupancy state machine, count and flag generation.
module fifo_ctrl
    import fifo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int THRESH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    output logic wr_ok,
    output logic rd_ok,
    output logic is_empty,
    output logic is_full,
    output logic err_over,
    output logic err_under,
    output logic low_level
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_LOW = CNT_W'(THRESH);

    occ_state_t       st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // State register, count and error pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= OCC_EMPTY;
            cnt       <= '0;
            err_over  <= 1'b0;
            err_under <= 1'b0;
        end else begin
            st        <= st_nxt;
            cnt       <= cnt_nxt;
            err_over  <= push && (st == OCC_FULL);
            err_under <= pop && (st == OCC_EMPTY);
        end
    end

    // Next state
    always_comb begin
        cnt_nxt = cnt + CNT_W'(wr_ok) - CNT_W'(rd_ok);
        st_nxt  = st;
        unique case (st)
            OCC_EMPTY: begin
                if (wr_ok) st_nxt = (cnt_nxt == CNT_MAX) ? OCC_FULL : OCC_PARTIAL; // first fill
            end
            OCC_PARTIAL: begin
                if (cnt_nxt == '0)          st_nxt = OCC_EMPTY; // last drain
                else if (cnt_nxt == CNT_MAX) st_nxt = OCC_FULL;  // top-off
            end
            OCC_FULL: begin
                if (rd_ok) st_nxt = OCC_PARTIAL;                 // free one
            end
            default: st_nxt = OCC_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        is_empty  = (st == OCC_EMPTY);
        is_full   = (st == OCC_FULL);
        wr_ok     = push && !is_full;
        rd_ok     = pop && !is_empty;
        low_level = (cnt < CNT_LOW);
    end
endmodule

// File: rtl/sync_fifo_flags.sv
module sync_fifo_flags #(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 8,
    parameter int THRESH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             is_empty,
    output logic             is_full,
    output logic             err_over,
    output logic             err_under,
    output logic             low_level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             wr_ok, rd_ok;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    fifo_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH)) u_ctrl (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .wr_ok(wr_ok), .rd_ok(rd_ok),
        .is_empty(is_empty), .is_full(is_full),
        .err_over(err_over), .err_under(err_under),
        .low_level(low_level)
    );

    fifo_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk(clk), .rst(rst), .adv(wr_ok), .ptr(wr_ptr)
    );

    fifo_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk(clk), .rst(rst), .adv(rd_ok), .ptr(rd_ptr)
    );

    fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok), .wr_addr(wr_ptr), .wr_word(push_data),
        .rd_en(rd_ok), .rd_addr(rd_ptr), .rd_word(pop_data)
    );
endmodule

// File: rtl/fifo_checker.sv
module fifo_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             push,
    input logic             pop,
    input logic [WIDTH-1:0] pop_data,
    input logic             is_empty,
    input logic             is_full,
    input logic             err_over,
    input logic             err_under,
    input logic             low_level
);
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(is_empty && is_full));

    assert_over_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (push && is_full) |=> err_over);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        !(push && is_full) |=> !err_over);

    assert_under_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (pop && is_empty) |=> err_under);

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        !(pop && is_empty) |=> !err_under);

    assert_hold_data_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && is_empty) |=> $stable(pop_data));

    assert_stay_full_R4: assert property (@(posedge clk) disable iff (rst)
        (is_full && !pop) |=> is_full);

    assert_stay_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (is_empty && !push) |=> is_empty);

    assert_low_when_empty_R9: assert property (@(posedge clk) disable iff (rst)
        is_empty |-> low_level);

    assert_not_low_when_full_R9: assert property (@(posedge clk) disable iff (rst)
        is_full |-> !low_level);
endmodule

bind sync_fifo_flags fifo_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .pop_data(pop_data),
    .is_empty(is_empty), .is_full(is_full), .err_over(err_over),
    .err_under(err_under), .low_level(low_level)
);

// File: tb/tb_sync_fifo_flags.sv
`timescale 1ns/1ps
module tb_sync_fifo_flags;
    localparam int DEPTH  = 8;
    localparam int THRESH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       is_empty, is_full, err_over, err_under, low_level;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [7:0] q[$];
    logic [7:0] exp_rd = '0;
    logic       exp_ovf = 1'b0;
    logic       exp_udf = 1'b0;

    always #10 clk = ~clk;

    sync_fifo_flags #(.WIDTH(8), .DEPTH(DEPTH), .THRESH(THRESH)) dut (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .is_empty(is_empty), .is_full(is_full),
        .err_over(err_over), .err_under(err_under), .low_level(low_level)
    );

    task automatic chk(input string scen, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", scen, what, act, exp);
        end
    endtask

    task automatic check_all(input string scen);
        chk(scen, "R2 pop_data",   pop_data, exp_rd);
        chk(scen, "R7 is_empty",   is_empty, (q.size() == 0));
        chk(scen, "R8 is_full",    is_full, (q.size() == DEPTH));
        chk(scen, "R3 err_over",   err_over, exp_ovf);
        chk(scen, "R5 err_under",  err_under, exp_udf);
        chk(scen, "R9 low_level",  low_level, (q.size() < THRESH));
    endtask

    task automatic cyc(input logic w, input logic [7:0] d, input logic r, input string scen);
        bit was_full, was_empty;
        @(negedge clk);
        push = w; push_data = d; pop = r;
        was_full  = (q.size() == DEPTH);
        was_empty = (q.size() == 0);
        exp_ovf = w && was_full;
        exp_udf = r && was_empty;
        if (r && !was_empty) exp_rd = q.pop_front();
        if (w && !was_full) q.push_back(d);
        @(posedge clk);
        #2;
        push = 1'b0; pop = 1'b0;
        check_all(scen);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        q.delete(); exp_rd = '0; exp_ovf = 1'b0; exp_udf = 1'b0;
        #1;
        check_all("R1 reset");
    endtask

    task automatic t_fill_overflow();
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 8'h10 + 8'(i), 1'b0, "R8 fill");
        cyc(1'b1, 8'hEE, 1'b0, "R4 push while full");
        cyc(1'b1, 8'hEF, 1'b0, "R4 push while full again");
        cyc(1'b0, 8'h00, 1'b0, "R3 pulse clears");
        for (int i = 0; i < DEPTH; i++) cyc(1'b0, 8'h00, 1'b1, "R4 drain intact");
    endtask

    task automatic t_underflow();
        cyc(1'b0, 8'h00, 1'b1, "R5 pop while empty");
        cyc(1'b0, 8'h00, 1'b1, "R6 data held");
        cyc(1'b0, 8'h00, 1'b0, "R5 pulse clears");
        cyc(1'b1, 8'hA5, 1'b0, "R6 push after underflow");
        cyc(1'b0, 8'h00, 1'b1, "R6 read position kept");
    endtask

    task automatic t_simultaneous();
        for (int i = 0; i < 3; i++) cyc(1'b1, 8'h30 + 8'(i), 1'b0, "R10 preload");
        for (int i = 0; i < 5; i++) cyc(1'b1, 8'h40 + 8'(i), 1'b1, "R10 push and pop");
        for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 1'b1, "R10 drain");
    endtask

    task automatic t_full_both();
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 8'h50 + 8'(i), 1'b0, "R12 fill");
        cyc(1'b1, 8'hCC, 1'b1, "R12 both while full");
        for (int i = 0; i < DEPTH - 1; i++) cyc(1'b0, 8'h00, 1'b1, "R12 drain after full");
    endtask

    task automatic t_empty_both();
        cyc(1'b1, 8'h77, 1'b1, "R12 both while empty");
        cyc(1'b0, 8'h00, 1'b1, "R12 word kept");
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 5; i++) cyc(1'b1, 8'h80 + 8'(i), 1'b0, "R11 prime");
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, 8'h90 + 8'(i), 1'b0, "R11 push");
            cyc(1'b0, 8'h00, 1'b1, "R11 pop");
        end
        for (int i = 0; i < 5; i++) cyc(1'b0, 8'h00, 1'b1, "R11 empty out");
    endtask

    initial begin
        #(200 * 1000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fill_overflow();
        t_underflow();
        t_simultaneous();
        t_full_both();
        t_empty_both();
        t_wrap();
        t_fill_overflow();
        t_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule